// File: doc/BRIEF.md
# Effective Address Sequencer

This block turns an addressing-mode code, the one or two operand bytes that follow an opcode, and the two index registers into a final 16-bit effective address. It also tells its consumer when the operand is not an address at all. Immediate operands and signed branch offsets are passed through with a kind tag that marks them as such.

Most modes are pure arithmetic and finish one cycle after the request. The three pointer-based modes are different. They fetch a little-endian pointer through an 8-bit synchronous read port that has one cycle of read latency, so they finish later. The caller pulses `start` with the request and waits for the single-cycle `done` pulse. The result and its tag then stay put until the next accepted request.

Top module: `ea_sequencer`

## Requirements
- R1: While `rstN` is low and after it rises, `done` and `memRe` are 0, `resultAddr` is 0x0000 and `resultKind` is 0.
- R2: The mode codes are 0 none, 1 immediate, 2 zero page, 3 zero page + X, 4 zero page + Y, 5 relative, 6 absolute, 7 absolute + X, 8 absolute + Y, 9 indirect, 10 pre-indexed indirect (X), and 11 post-indexed indirect (Y). Codes 12 to 15 behave as code 0. The kind codes are 0 none, 1 immediate, 2 relative and 3 address. Mode 0 yields kind 0 and address 0x0000.
- R3: Immediate yields kind 1 with the operand byte in `resultAddr[7:0]` and zeros above it. Relative yields kind 2 with the operand byte sign-extended to 16 bits.
- R4: The zero-page modes yield kind 3. The address is the low operand byte plus the index, modulo 256, and the upper byte is 0x00. For example, 0xFF + X=1 gives 0x0000.
- R5: Absolute modes form the base as `opHi:opLo`. The indexed forms add X or Y modulo 65536, so 0xFFFF + 2 gives 0x0001.
- R6: Modes other than 9 to 11 assert `done` exactly one cycle after the accepting edge and issue no memory read.
- R7: The indirect modes read the pointer low byte and then the high byte on two consecutive cycles. Read data returns one cycle after each read, and `done` is visible four cycles after the accepting edge. The result is `high:low`. In mode 9 the high byte is read at the 16-bit pointer + 1, so 0xFFFF wraps to 0x0000.
- R8: In mode 10 the pointer is (`opLo` + X) mod 256 in page zero. Its high byte is read at the next page-zero location, with the offset wrapping from 0xFF to 0x00.
- R9: In mode 11 the pointer is `opLo` in page zero, and its high byte also wraps within page zero. The fetched pointer plus Y, modulo 65536, is the result, using the Y value sampled on the accepting edge.
- R10: A `start` while a pointer fetch is in progress is ignored. It changes neither the result nor the read sequence, and it produces no extra `done`.
- R11: `done` is a single-cycle pulse for each accepted request. `resultAddr` and `resultKind` change only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, sampled on the rising edge |
| mode | input | 4 | Addressing-mode code |
| opLo | input | 8 | First operand byte |
| opHi | input | 8 | Second operand byte |
| idxX | input | 8 | X index register |
| idxY | input | 8 | Y index register |
| memAddr | output | 16 | Pointer read address |
| memRe | output | 1 | Pointer read enable |
| memRdata | input | 8 | Read data, one cycle after `memRe` |
| done | output | 1 | Result-valid pulse |
| resultAddr | output | 16 | Effective address, immediate value or offset |
| resultKind | output | 2 | Tag for `resultAddr` |

## Verification
A corrupted fetch state appears at the ports in one of two ways: the read pair goes to the wrong pair of locations, or `done` arrives at the wrong cycle. Both are seen within four cycles of the request. A bad pointer or low-byte register shows up at the next `done` as a wrong address. This is most telling where page-zero wrap and 16-bit wrap diverge. A request leaking in while busy shows up as a change of result without `done`, or as an extra pulse on the cycle after completion.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [3:0] {
    MODE_NONE = 4'd0, MODE_IMM = 4'd1, MODE_ZP = 4'd2, MODE_ZPX = 4'd3,
    MODE_ZPY = 4'd4, MODE_REL = 4'd5, MODE_ABS = 4'd6, MODE_ABSX = 4'd7,
    MODE_ABSY = 4'd8, MODE_IND = 4'd9, MODE_PREX = 4'd10, MODE_POSTY = 4'd11,
    MODE_R12 = 4'd12, MODE_R13 = 4'd13, MODE_R14 = 4'd14, MODE_R15 = 4'd15
  } mode_e;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0, KIND_IMM = 2'd1, KIND_REL = 2'd2, KIND_ADDR = 2'd3
  } kind_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic acceptDirect;
    logic acceptInd;
    logic readLo;
    logic readHi;
    logic finish;
  } ctl_s;

  function automatic logic isPointerMode(mode_e m);
    return (m == MODE_IND) || (m == MODE_PREX) || (m == MODE_POSTY);
  endfunction
endpackage

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  start,
  input  mode_e modeIn,
  output ctl_s  ctl,
  output logic  busy,
  output logic  done
);
  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI, S_WAIT} state_e;
  state_e state;

  always_comb begin
    busy             = (state != S_IDLE);
    ctl.acceptDirect = start && !busy && !isPointerMode(modeIn);
    ctl.acceptInd    = start && !busy && isPointerMode(modeIn);
    ctl.readLo       = (state == S_LO);
    ctl.readHi       = (state == S_HI);
    ctl.finish       = (state == S_WAIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      done <= ctl.acceptDirect || ctl.finish;
      unique case (state)
        S_IDLE:  if (ctl.acceptInd) state <= S_LO;
        S_LO:    state <= S_HI;
        S_HI:    state <= S_WAIT;
        S_WAIT:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_lo_then_hi_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.readLo |=> ctl.readHi);
  assert_hi_after_lo_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.readHi |-> $past(ctl.readLo));
  assert_no_done_while_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done);
endmodule

// File: rtl/ea_dp.sv
module ea_dp
  import ea_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int ADDR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_s              ctl,
  input  mode_e             modeIn,
  input  logic [BYTE_W-1:0] opLo,
  input  logic [BYTE_W-1:0] opHi,
  input  logic [BYTE_W-1:0] idxX,
  input  logic [BYTE_W-1:0] idxY,
  input  logic [BYTE_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  output logic [ADDR_W-1:0] resultAddr,
  output kind_e             resultKind
);
  localparam logic [BYTE_W-1:0] ZERO_B = '0;

  mode_e             modeQ;
  logic [BYTE_W-1:0] yQ, loQ;
  logic [ADDR_W-1:0] ptrQ, ptrNext, ptrStart, directAddr, finalAddr;
  logic [BYTE_W-1:0] zpX, zpY;
  kind_e             directKind;

  assign zpX = opLo + idxX;
  assign zpY = opLo + idxY;

  always_comb begin
    directKind = KIND_ADDR;
    directAddr = '0;
    unique case (modeIn)
      MODE_IMM:  begin directKind = KIND_IMM; directAddr = {ZERO_B, opLo}; end
      MODE_REL:  begin directKind = KIND_REL; directAddr = {{BYTE_W{opLo[BYTE_W-1]}}, opLo}; end
      MODE_ZP:   directAddr = {ZERO_B, opLo};
      MODE_ZPX:  directAddr = {ZERO_B, zpX};
      MODE_ZPY:  directAddr = {ZERO_B, zpY};
      MODE_ABS:  directAddr = {opHi, opLo};
      MODE_ABSX: directAddr = {opHi, opLo} + {ZERO_B, idxX};
      MODE_ABSY: directAddr = {opHi, opLo} + {ZERO_B, idxY};
      default:   begin directKind = KIND_NONE; directAddr = '0; end
    endcase
  end

  always_comb begin
    unique case (modeIn)
      MODE_IND:  ptrStart = {opHi, opLo};
      MODE_PREX: ptrStart = {ZERO_B, zpX};
      default:   ptrStart = {ZERO_B, opLo};
    endcase
  end

  // The pointer high byte wraps within page zero except in the absolute pointer mode
  assign ptrNext   = (modeQ == MODE_IND) ? ptrQ + 1'b1 : {ZERO_B, ptrQ[BYTE_W-1:0] + 1'b1};
  assign memAddr   = ctl.readHi ? ptrNext : ptrQ;
  assign memRe     = ctl.readLo || ctl.readHi;
  assign finalAddr = {memRdata, loQ} + ((modeQ == MODE_POSTY) ? {ZERO_B, yQ} : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ      <= MODE_NONE;
      yQ         <= '0;
      loQ        <= '0;
      ptrQ       <= '0;
      resultAddr <= '0;
      resultKind <= KIND_NONE;
    end else begin
      if (ctl.acceptInd) begin
        modeQ <= modeIn;
        yQ    <= idxY;
        ptrQ  <= ptrStart;
      end
      if (ctl.readHi) loQ <= memRdata;
      if (ctl.acceptDirect) begin
        resultAddr <= directAddr;
        resultKind <= directKind;
      end else if (ctl.finish) begin
        resultAddr <= finalAddr;
        resultKind <= KIND_ADDR;
      end
    end
  end

  assert_zp_pointer_page_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memRe && modeQ != MODE_IND) |-> (memAddr[ADDR_W-1:BYTE_W] == ZERO_B));
  assert_ind_hi_next_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.readHi && modeQ == MODE_IND) |-> (memAddr == $past(memAddr) + 1'b1));
endmodule

// File: rtl/ea_sequencer.sv
module ea_sequencer
  import ea_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int ADDR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [3:0]        mode,
  input  logic [BYTE_W-1:0] opLo,
  input  logic [BYTE_W-1:0] opHi,
  input  logic [BYTE_W-1:0] idxX,
  input  logic [BYTE_W-1:0] idxY,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  input  logic [BYTE_W-1:0] memRdata,
  output logic              done,
  output logic [ADDR_W-1:0] resultAddr,
  output logic [1:0]        resultKind
);
  mode_e modeIn;
  ctl_s  ctl;
  logic  busy;
  kind_e kindQ;

  assign modeIn     = mode_e'(mode);
  assign resultKind = kindQ;

  ea_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .modeIn(modeIn),
    .ctl(ctl), .busy(busy), .done(done)
  );

  ea_dp #(.BYTE_W(BYTE_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .modeIn(modeIn),
    .opLo(opLo), .opHi(opHi), .idxX(idxX), .idxY(idxY),
    .memRdata(memRdata), .memAddr(memAddr), .memRe(memRe),
    .resultAddr(resultAddr), .resultKind(kindQ)
  );

  assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(resultAddr) && $stable(resultKind)));
  assert_no_read_on_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memRe);
endmodule

// File: tb/ea_sequencer_test.sv
module ea_sequencer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [7:0]  opLo = '0, opHi = '0, idxX = '0, idxY = '0;
  logic [15:0] memAddr;
  logic        memRe;
  logic [7:0]  memRdata = '0;
  logic        done;
  logic [15:0] resultAddr;
  logic [1:0]  resultKind;

  int checks = 0;
  int errors = 0;
  int readTotal = 0;
  logic [15:0] prevRd = '0, lastRd = '0;

  always #4 clk = ~clk;

  ea_sequencer uut (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .opLo(opLo), .opHi(opHi),
    .idxX(idxX), .idxY(idxY), .memAddr(memAddr), .memRe(memRe), .memRdata(memRdata),
    .done(done), .resultAddr(resultAddr), .resultKind(resultKind)
  );

  function automatic logic [7:0] memf(logic [15:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h5A;
  endfunction

  // Behavioural synchronous memory: one cycle of read latency
  always @(posedge clk) memRdata <= memRe ? memf(memAddr) : 8'hC3;

  always @(negedge clk) if (memRe) begin
    prevRd    = lastRd;
    lastRd    = memAddr;
    readTotal = readTotal + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReq(input logic [3:0] m, input logic [7:0] a0, input logic [7:0] a1,
                       input logic [7:0] xv, input logic [7:0] yv, input bit poke);
    logic [15:0] expAddr, p0, p1;
    logic [1:0]  expKind;
    int          expLat, expReads, lat, base;
    bit          seen;
    logic [15:0] heldAddr;
    logic [1:0]  heldKind;
    string       tag;
    p0 = '0; p1 = '0; expKind = 2'd3; expLat = 1; expReads = 0;
    case (m)
      4'd1: begin expKind = 2'd1; expAddr = {8'h00, a0}; tag = "R3"; end
      4'd5: begin expKind = 2'd2; expAddr = {{8{a0[7]}}, a0}; tag = "R3"; end
      4'd2: begin expAddr = {8'h00, a0}; tag = "R4"; end
      4'd3: begin expAddr = {8'h00, 8'(a0 + xv)}; tag = "R4"; end
      4'd4: begin expAddr = {8'h00, 8'(a0 + yv)}; tag = "R4"; end
      4'd6: begin expAddr = {a1, a0}; tag = "R5"; end
      4'd7: begin expAddr = 16'({a1, a0} + xv); tag = "R5"; end
      4'd8: begin expAddr = 16'({a1, a0} + yv); tag = "R5"; end
      4'd9: begin p0 = {a1, a0}; p1 = p0 + 16'd1; tag = "R7"; end
      4'd10: begin p0 = {8'h00, 8'(a0 + xv)}; p1 = {8'h00, 8'(p0[7:0] + 8'd1)}; tag = "R8"; end
      4'd11: begin p0 = {8'h00, a0}; p1 = {8'h00, 8'(a0 + 8'd1)}; tag = "R9"; end
      default: begin expKind = 2'd0; expAddr = '0; tag = "R2"; end
    endcase
    if (m >= 4'd9 && m <= 4'd11) begin
      expLat = 4; expReads = 2;
      expAddr = {memf(p1), memf(p0)} + ((m == 4'd11) ? {8'h00, yv} : 16'h0000);
    end
    base = readTotal;
    start = 1'b1; mode = m; opLo = a0; opHi = a1; idxX = xv; idxY = yv;
    lat = 0; seen = 0;
    while (!seen && lat < 10) begin
      @(negedge clk);
      lat++;
      if (done) begin
        seen = 1; start = 1'b0;
      end else if (poke) begin
        start = 1'b1; mode = 4'd1; opLo = 8'h77; idxY = idxY ^ 8'hA5; idxX = idxX + 8'd3;
      end else begin
        start = 1'b0;
      end
    end
    chk(lat == expLat, (expLat == 1) ? "R6 latency" : "R7 latency", lat, expLat);
    chk(resultAddr == expAddr, tag, resultAddr, expAddr);
    chk(resultKind == expKind, "R2 kind", resultKind, expKind);
    chk(readTotal - base == expReads, poke ? "R10 read count" : "R6 read count", readTotal - base, expReads);
    if (expReads == 2) begin
      chk(prevRd == p0, "R7 low pointer read", prevRd, p0);
      chk(lastRd == p1, "R7 high pointer read", lastRd, p1);
    end
    heldAddr = resultAddr; heldKind = resultKind;
    @(negedge clk);
    chk(!done, poke ? "R10 extra done" : "R11 done pulse", done, 0);
    chk(resultAddr == heldAddr && resultKind == heldKind, "R11 hold", resultAddr, heldAddr);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(!done && !memRe, "R1 reset strobes", {done, memRe}, 0);
    chk(resultAddr == 16'h0 && resultKind == 2'd0, "R1 reset result", resultAddr, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!done && !memRe && resultAddr == 16'h0, "R1 after reset", resultAddr, 0);
    // Directed corner cases
    doReq(4'd0, 8'h12, 8'h34, 8'h01, 8'h02, 0);
    doReq(4'd13, 8'h12, 8'h34, 8'h01, 8'h02, 0);
    doReq(4'd1, 8'hAB, 8'h00, 8'h00, 8'h00, 0);
    doReq(4'd5, 8'h80, 8'h00, 8'h00, 8'h00, 0);
    doReq(4'd5, 8'h7F, 8'h00, 8'h00, 8'h00, 0);
    doReq(4'd3, 8'hFF, 8'h00, 8'h01, 8'h00, 0);
    doReq(4'd4, 8'h80, 8'h00, 8'h00, 8'h90, 0);
    doReq(4'd7, 8'hFF, 8'hFF, 8'h02, 8'h00, 0);
    doReq(4'd8, 8'hF0, 8'h12, 8'h00, 8'h20, 0);
    doReq(4'd9, 8'hFF, 8'h12, 8'h00, 8'h00, 0);
    doReq(4'd9, 8'hFF, 8'hFF, 8'h00, 8'h00, 0);
    doReq(4'd10, 8'hFE, 8'h55, 8'h01, 8'h00, 0);
    doReq(4'd10, 8'h80, 8'h00, 8'h7F, 8'h00, 1);
    doReq(4'd11, 8'hFF, 8'h00, 8'h00, 8'hFF, 0);
    doReq(4'd11, 8'h40, 8'h00, 8'h00, 8'h10, 1);
    // Constrained random
    for (int i = 0; i < 300; i++) begin
      doReq(4'($urandom % 16), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
            ($urandom % 4) == 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule